// File: doc/BRIEF.md
# Programmable LCD Sync Timing Generator

This block produces the raster timing for a parallel RGB LCD panel. A pixel-rate tick is derived from the input clock, either 1:1 or through a programmable integer divider. On every tick a horizontal sequencer walks through four phases in a fixed order: sync, back porch, active, front porch. The last tick of a line's front porch steps a vertical sequencer through the same four phases, counted in lines. From these two positions the block drives horizontal sync, vertical sync, data enable and the active-area pixel coordinates. Both sync outputs pass through an XOR with a polarity input.

Every length input is written as the count minus one. A frame lasts (hsync + hbp + width + hfp) x (vsync + vbp + height + vfp) pixel ticks. A run-control state machine has three states. In `RS_IDLE` the position is held at frame start and all outputs are inactive. In `RS_RUN` it counts and keeps wrapping frames. In `RS_DRAIN` the enable has been withdrawn, but counting continues to the end of the current frame. The transitions are:
- *start*: `RS_IDLE` to `RS_RUN`, when enable is high on a tick.
- *drain*: `RS_RUN` to `RS_DRAIN`, when enable falls.
- *resume*: `RS_DRAIN` to `RS_RUN`, when enable returns.
- *finish*: `RS_RUN` or `RS_DRAIN` to `RS_IDLE`, on the last tick of a frame while enable is low.

Each frame start is the start of the vertical sync period. When both interrupt enables are set, a frame start sets a pending flag. Software clears the flag by pulsing a write-one-to-clear input.

Top module: `lcd_sync_gen`

## Requirements
- R1: After reset, de is 0 and pix_x, pix_y, frame_pend and frame_irq are 0. hsync equals hsync_pol and vsync equals vsync_pol.
- R2: With div_sel = 0, pix_en is high on every clock cycle.
- R3: With div_sel = 1, pix_en is high once every div_m1 + 1 cycles. Each pixel position then lasts that many cycles.
- R4: The horizontal phases run in this order: sync for h_sync_m1+1 ticks, back porch for h_back_m1+1, active for h_act_m1+1, front porch for h_front_m1+1. hsync is asserted (high when hsync_pol = 0) only during the sync phase.
- R5: The vertical phases run in the same order, counted in lines, with lengths v_sync_m1+1, v_back_m1+1, v_act_m1+1 and v_front_m1+1. vsync is asserted (high when vsync_pol = 0) only during vertical sync.
- R6: de is 1 only when both axes are in their active phase. pix_x and pix_y count from 0 inside the active phase and read 0 outside it.
- R7: A running frame repeats every (sum of horizontal lengths) x (sum of vertical lengths) pixel ticks.
- R8: When enable is high on a tick in idle, the next cycle presents the frame-start pixel: first horizontal sync tick of the first vertical sync line.
- R9: When enable falls, counting continues to the end of the frame, then the outputs go idle as in R1. A later enable restarts at frame start.
- R10: Each frame start sets frame_pend when irq_global_en and irq_frame_en are both 1. With either one 0, frame_pend is not set.
- R11: A one-cycle pulse on irq_clear clears frame_pend. If a set and a clear fall in the same cycle, the set wins.
- R12: frame_irq equals frame_pend AND irq_global_en AND irq_frame_en.
- R13: Setting hsync_pol or vsync_pol inverts the respective sync output in every state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Source clock |
| rst_n | input | 1 | Active-low synchronous reset |
| enable | input | 1 | Run request |
| div_sel | input | 1 | 1 selects the divider, 0 runs 1:1 |
| div_m1 | input | DIV_W | Divide ratio minus one |
| h_sync_m1 | input | H_W | Horizontal sync width minus one |
| h_back_m1 | input | H_W | Horizontal back porch minus one |
| h_act_m1 | input | H_W | Active pixels per line minus one |
| h_front_m1 | input | H_W | Horizontal front porch minus one |
| v_sync_m1 | input | V_W | Vertical sync width minus one (lines) |
| v_back_m1 | input | V_W | Vertical back porch minus one |
| v_act_m1 | input | V_W | Active lines minus one |
| v_front_m1 | input | V_W | Vertical front porch minus one |
| hsync_pol | input | 1 | XOR applied to hsync |
| vsync_pol | input | 1 | XOR applied to vsync |
| irq_global_en | input | 1 | Global interrupt enable |
| irq_frame_en | input | 1 | Frame interrupt enable |
| irq_clear | input | 1 | Write-one pulse clearing frame_pend |
| pix_en | output | 1 | Pixel-rate tick |
| hsync | output | 1 | Horizontal sync |
| vsync | output | 1 | Vertical sync |
| de | output | 1 | Data enable |
| pix_x | output | H_W | Active-area column |
| pix_y | output | V_W | Active-area row |
| frame_pend | output | 1 | Frame pending flag |
| frame_irq | output | 1 | Masked frame interrupt |

## Verification
Position changes happen on a clock edge where pix_en is high. The new pixel's hsync, vsync, de and coordinates are visible in the cycle that follows. The start transition therefore shows the frame-start pixel one cycle after the enabling tick. frame_pend rises one cycle after the frame-start edge, and falls one cycle after the clear pulse. The bench drives and samples on the falling edge. It keeps its own pixel index and advances that index only after a sample in which pix_en was seen high, so every comparison lands in the cycle the design's registers place the result.

// File: rtl/lcd_sync_pkg.sv
`timescale 1ns/1ps
package lcd_sync_pkg;

    typedef enum logic [1:0] {
        PH_SYNC   = 2'd0,
        PH_BACK   = 2'd1,
        PH_ACTIVE = 2'd2,
        PH_FRONT  = 2'd3
    } phase_e;

    typedef enum logic [1:0] {
        RS_IDLE  = 2'd0,
        RS_RUN   = 2'd1,
        RS_DRAIN = 2'd2
    } run_e;

    function automatic phase_e next_phase(input phase_e cur);
        phase_e nxt;
        unique case (cur)
            PH_SYNC:   nxt = PH_BACK;
            PH_BACK:   nxt = PH_ACTIVE;
            PH_ACTIVE: nxt = PH_FRONT;
            default:   nxt = PH_SYNC;
        endcase
        return nxt;
    endfunction

endpackage

// File: rtl/lcd_pix_div.sv
`timescale 1ns/1ps
module lcd_pix_div #(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             div_sel,
    input  logic [DIV_W-1:0] div_m1,
    output logic             pix_en
);
    logic [DIV_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (!div_sel || cnt_q >= div_m1) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    always_comb begin
        pix_en = !div_sel || (cnt_q == '0);
    end

    // R3: a divided tick is never followed at once by another
    p_div_gap_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (div_sel && pix_en && div_m1 != '0) |=> (!pix_en || !div_sel));

endmodule

// File: rtl/lcd_axis_seq.sv
`timescale 1ns/1ps
module lcd_axis_seq
    import lcd_sync_pkg::*;
#(
    parameter int CW = 11
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clear,
    input  logic          step,
    input  logic [CW-1:0] sync_m1,
    input  logic [CW-1:0] back_m1,
    input  logic [CW-1:0] act_m1,
    input  logic [CW-1:0] front_m1,
    output phase_e        phase,
    output logic [CW-1:0] pos,
    output logic          last,
    output logic          in_sync,
    output logic          in_active,
    output logic [CW-1:0] coord
);
    phase_e        phase_q;
    logic [CW-1:0] cnt_q;
    logic [CW-1:0] cur_len;
    logic          at_end;

    always_comb begin
        unique case (phase_q)
            PH_SYNC:   cur_len = sync_m1;
            PH_BACK:   cur_len = back_m1;
            PH_ACTIVE: cur_len = act_m1;
            default:   cur_len = front_m1;
        endcase
        at_end = (cnt_q == cur_len);
    end

    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            phase_q <= PH_SYNC;
            cnt_q   <= '0;
        end else if (step) begin
            if (at_end) begin
                phase_q <= next_phase(phase_q);
                cnt_q   <= '0;
            end else begin
                cnt_q   <= cnt_q + 1'b1;
            end
        end
    end

    always_comb begin
        phase     = phase_q;
        pos       = cnt_q;
        last      = (phase_q == PH_FRONT) && at_end;
        in_sync   = (phase_q == PH_SYNC);
        in_active = (phase_q == PH_ACTIVE);
        coord     = in_active ? cnt_q : '0;
    end

    // R4: position frozen without a step
    p_hold_no_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!step && !clear) |=> ($stable(phase_q) && $stable(cnt_q)));

    // R5: phases only move forward in the fixed order
    p_phase_order_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !clear |=> (phase_q == $past(phase_q) || phase_q == next_phase($past(phase_q))));

endmodule

// File: rtl/lcd_frame_irq.sv
`timescale 1ns/1ps
module lcd_frame_irq (
    input  logic clk,
    input  logic rst_n,
    input  logic frame_start,
    input  logic global_en,
    input  logic frame_en,
    input  logic clr_w1,
    output logic pend,
    output logic irq
);
    logic pend_q;
    logic set_evt;

    always_comb begin
        set_evt = frame_start && global_en && frame_en;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_q <= 1'b0;
        end else if (set_evt) begin
            pend_q <= 1'b1;
        end else if (clr_w1) begin
            pend_q <= 1'b0;
        end
    end

    always_comb begin
        pend = pend_q;
        irq  = pend_q && global_en && frame_en;
    end

    p_pend_set_r10: assert property (@(posedge clk) disable iff (!rst_n)
        set_evt |=> pend_q);

    p_pend_clear_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_w1 && !set_evt) |=> !pend_q);

    p_pend_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr_w1 && !set_evt) |=> $stable(pend_q));

endmodule

// File: rtl/lcd_sync_gen.sv
`timescale 1ns/1ps
module lcd_sync_gen
    import lcd_sync_pkg::*;
#(
    parameter int H_W   = 11,
    parameter int V_W   = 11,
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             enable,
    input  logic             div_sel,
    input  logic [DIV_W-1:0] div_m1,
    input  logic [H_W-1:0]   h_sync_m1,
    input  logic [H_W-1:0]   h_back_m1,
    input  logic [H_W-1:0]   h_act_m1,
    input  logic [H_W-1:0]   h_front_m1,
    input  logic [V_W-1:0]   v_sync_m1,
    input  logic [V_W-1:0]   v_back_m1,
    input  logic [V_W-1:0]   v_act_m1,
    input  logic [V_W-1:0]   v_front_m1,
    input  logic             hsync_pol,
    input  logic             vsync_pol,
    input  logic             irq_global_en,
    input  logic             irq_frame_en,
    input  logic             irq_clear,
    output logic             pix_en,
    output logic             hsync,
    output logic             vsync,
    output logic             de,
    output logic [H_W-1:0]   pix_x,
    output logic [V_W-1:0]   pix_y,
    output logic             frame_pend,
    output logic             frame_irq
);
    run_e state_q, state_d;

    logic           tick;
    logic           running, home, adv, frame_last, frame_start;
    phase_e         h_phase, v_phase;
    logic [H_W-1:0] h_pos, h_coord;
    logic [V_W-1:0] v_pos, v_coord;
    logic           h_last, v_last, h_sync_i, v_sync_i, h_act_i, v_act_i;

    lcd_pix_div #(.DIV_W(DIV_W)) u_div (
        .clk(clk), .rst_n(rst_n), .div_sel(div_sel), .div_m1(div_m1), .pix_en(tick)
    );

    always_comb begin
        running    = (state_q != RS_IDLE);
        home       = (state_q == RS_IDLE);
        adv        = running && tick;
        frame_last = h_last && v_last;
        frame_start = (home && enable && tick) || (adv && frame_last && enable);
    end

    lcd_axis_seq #(.CW(H_W)) u_h (
        .clk(clk), .rst_n(rst_n), .clear(home), .step(adv),
        .sync_m1(h_sync_m1), .back_m1(h_back_m1), .act_m1(h_act_m1), .front_m1(h_front_m1),
        .phase(h_phase), .pos(h_pos), .last(h_last),
        .in_sync(h_sync_i), .in_active(h_act_i), .coord(h_coord)
    );

    lcd_axis_seq #(.CW(V_W)) u_v (
        .clk(clk), .rst_n(rst_n), .clear(home), .step(adv && h_last),
        .sync_m1(v_sync_m1), .back_m1(v_back_m1), .act_m1(v_act_m1), .front_m1(v_front_m1),
        .phase(v_phase), .pos(v_pos), .last(v_last),
        .in_sync(v_sync_i), .in_active(v_act_i), .coord(v_coord)
    );

    lcd_frame_irq u_irq (
        .clk(clk), .rst_n(rst_n), .frame_start(frame_start),
        .global_en(irq_global_en), .frame_en(irq_frame_en), .clr_w1(irq_clear),
        .pend(frame_pend), .irq(frame_irq)
    );

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= RS_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // transitions: start, drain, resume, finish
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            RS_IDLE: begin
                if (enable && tick) state_d = RS_RUN;
            end
            RS_RUN: begin
                if (!enable) state_d = (tick && frame_last) ? RS_IDLE : RS_DRAIN;
            end
            RS_DRAIN: begin
                if (enable)                 state_d = RS_RUN;
                else if (tick && frame_last) state_d = RS_IDLE;
            end
            default: state_d = RS_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        pix_en = tick;
        hsync  = (running && h_sync_i) ^ hsync_pol;
        vsync  = (running && v_sync_i) ^ vsync_pol;
        de     = running && h_act_i && v_act_i;
        pix_x  = running ? h_coord : '0;
        pix_y  = running ? v_coord : '0;
    end

    // R9: idle always parks both sequencers at frame start
    p_idle_home_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == RS_IDLE) |-> (h_phase == PH_SYNC && h_pos == '0 &&
                                  v_phase == PH_SYNC && v_pos == '0));

endmodule

// File: tb/lcd_sync_gen_tb_top.sv
`timescale 1ns/1ps
module lcd_sync_gen_tb_top;
    localparam int H_W = 11, V_W = 11, DIV_W = 8;
    localparam int HS = 2, HB = 1, HA = 4, HF = 2;
    localparam int VS = 1, VB = 1, VA = 3, VF = 1;
    localparam int HT = HS + HB + HA + HF;
    localparam int VT = VS + VB + VA + VF;
    localparam int FP = HT * VT;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic enable = 1'b0, div_sel = 1'b0;
    logic [DIV_W-1:0] div_m1 = '0;
    logic hsync_pol = 1'b0, vsync_pol = 1'b0;
    logic irq_global_en = 1'b0, irq_frame_en = 1'b0, irq_clear = 1'b0;
    logic pix_en, hsync, vsync, de, frame_pend, frame_irq;
    logic [H_W-1:0] pix_x;
    logic [V_W-1:0] pix_y;

    int checks = 0, fails = 0, n = 0;

    always #5 clk = ~clk;

    lcd_sync_gen #(.H_W(H_W), .V_W(V_W), .DIV_W(DIV_W)) dut_i (
        .clk(clk), .rst_n(rst_n), .enable(enable), .div_sel(div_sel), .div_m1(div_m1),
        .h_sync_m1(H_W'(HS-1)), .h_back_m1(H_W'(HB-1)), .h_act_m1(H_W'(HA-1)), .h_front_m1(H_W'(HF-1)),
        .v_sync_m1(V_W'(VS-1)), .v_back_m1(V_W'(VB-1)), .v_act_m1(V_W'(VA-1)), .v_front_m1(V_W'(VF-1)),
        .hsync_pol(hsync_pol), .vsync_pol(vsync_pol),
        .irq_global_en(irq_global_en), .irq_frame_en(irq_frame_en), .irq_clear(irq_clear),
        .pix_en(pix_en), .hsync(hsync), .vsync(vsync), .de(de), .pix_x(pix_x), .pix_y(pix_y),
        .frame_pend(frame_pend), .frame_irq(frame_irq)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // compare all raster outputs against pixel index n of a running frame
    task automatic check_pixel(input string req);
        int k, h, v, ex_hs, ex_vs, ex_de, ex_x, ex_y;
        k = n % FP; h = k % HT; v = k / HT;
        ex_hs = (h < HS) ? 1 : 0;
        ex_vs = (v < VS) ? 1 : 0;
        ex_x = (h >= HS + HB && h < HS + HB + HA) ? h - HS - HB : 0;
        ex_y = (v >= VS + VB && v < VS + VB + VA) ? v - VS - VB : 0;
        ex_de = (h >= HS + HB && h < HS + HB + HA && v >= VS + VB && v < VS + VB + VA) ? 1 : 0;
        chk({req, " hsync R4"}, int'(hsync), ex_hs ^ int'(hsync_pol));
        chk({req, " vsync R5"}, int'(vsync), ex_vs ^ int'(vsync_pol));
        chk({req, " de R6"}, int'(de), ex_de);
        chk({req, " x R6"}, int'(pix_x), ex_x);
        chk({req, " y R6"}, int'(pix_y), ex_y);
    endtask

    task automatic check_idle(input string req);
        chk({req, " idle hsync"}, int'(hsync), int'(hsync_pol));
        chk({req, " idle vsync"}, int'(vsync), int'(vsync_pol));
        chk({req, " idle de"}, int'(de), 0);
        chk({req, " idle x"}, int'(pix_x), 0);
        chk({req, " idle y"}, int'(pix_y), 0);
    endtask

    task automatic step_pix(input string req);
        check_pixel(req);
        if (pix_en) n++;
        @(negedge clk);
    endtask

    // R8: enable on a tick, frame-start pixel due the next cycle
    task automatic start_run();
        while (!pix_en) @(negedge clk);
        enable = 1'b1;
        @(negedge clk);
        n = 0;
    endtask

    task automatic t_reset();
        chk("R1 pend", int'(frame_pend), 0);
        chk("R1 irq", int'(frame_irq), 0);
        check_idle("R1");
    endtask

    task automatic t_bypass_frame();
        int cyc;
        irq_global_en = 1'b1; irq_frame_en = 1'b1;
        for (int i = 0; i < 4; i++) begin
            chk("R2 pix_en every cycle", int'(pix_en), 1);
            @(negedge clk);
        end
        start_run();
        chk("R8 frame start hsync", int'(hsync), 1);
        chk("R10 pend at vsync start", int'(frame_pend), 1);
        chk("R12 irq", int'(frame_irq), 1);
        irq_clear = 1'b1;
        step_pix("R8");
        irq_clear = 1'b0;
        chk("R11 cleared", int'(frame_pend), 0);
        cyc = 1;
        while (n < FP) begin
            if (n == FP - 1) chk("R10 no early pend", int'(frame_pend), 0);
            step_pix("R4");
            cyc++;
        end
        chk("R7 frame period cycles", cyc, FP);
        chk("R10 pend at wrap", int'(frame_pend), 1);
        check_pixel("R7 wrap");
    endtask

    task automatic t_set_wins();
        irq_clear = 1'b1;
        @(negedge clk);
        irq_clear = 1'b0;
        n++;
        chk("R11 clear", int'(frame_pend), 0);
        while (n % FP != FP - 1) step_pix("R5");
        irq_clear = 1'b1;
        step_pix("R11");
        irq_clear = 1'b0;
        chk("R11 set wins", int'(frame_pend), 1);
        irq_frame_en = 1'b0;
        @(negedge clk); n++;
        chk("R12 masked irq", int'(frame_irq), 0);
        chk("R12 pend kept", int'(frame_pend), 1);
        irq_frame_en = 1'b1;
        irq_clear = 1'b1;
        @(negedge clk); n++;
        irq_clear = 1'b0;
    endtask

    task automatic t_masked();
        irq_global_en = 1'b0;
        while (n % FP != 0) step_pix("R10");
        step_pix("R10");
        chk("R10 no set when masked", int'(frame_pend), 0);
        irq_global_en = 1'b1;
    endtask

    task automatic t_drain();
        n = n % FP;
        while (n < 20) step_pix("R9");
        enable = 1'b0;
        while (n < FP) step_pix("R9 drain");
        for (int i = 0; i < 4; i++) begin
            check_idle("R9");
            @(negedge clk);
        end
        start_run();
        check_pixel("R9 restart");
        chk("R9 restart pend", int'(frame_pend), 1);
        irq_clear = 1'b1; step_pix("R9"); irq_clear = 1'b0;
        enable = 1'b0;
        while (n < FP) step_pix("R9 drain2");
        check_idle("R9 stop2");
    endtask

    task automatic t_divider();
        int highs, cyc;
        div_sel = 1'b1; div_m1 = 8'd2;
        @(negedge clk);
        highs = 0;
        for (int i = 0; i < 12; i++) begin
            if (pix_en) highs++;
            @(negedge clk);
        end
        chk("R3 tick count", highs, 4);
        hsync_pol = 1'b1; vsync_pol = 1'b1;
        @(negedge clk);
        check_idle("R13");
        start_run();
        cyc = 0;
        while (n < FP) begin
            step_pix("R3 R13");
            cyc++;
        end
        chk("R3 divided frame period", cyc, 3 * FP);
        enable = 1'b0;
        while (n < 2 * FP) step_pix("R3");
        check_idle("R13 idle");
    endtask

    initial begin
        #1_000_000;
        fails++; checks++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_bypass_frame();
        t_set_wins();
        t_masked();
        t_drain();
        t_divider();
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule